// File: doc/BRIEF.md
# Multi-Channel Prescaled Down-Counter Timer

This peripheral holds two or three independent 32-bit countdown channels behind one small synchronous register port. Every channel has a reload value, a live counter and a control word. The control word picks a clock divisor, enables the channel's interrupt, and holds a sticky underflow flag. One shared 8-bit run register starts and stops the channels, one bit per channel.

While its run bit is set, a channel's prescaler counts peripheral clocks. Each prescaled tick moves the counter down by one, so software can read the counter and invert it to get a rising elapsed-time value. When a tick finds the counter at zero, the counter takes the reload value and the underflow flag is set. The flag drives a level interrupt for as long as it stays set and the channel's interrupt enable is on. Software clears the flag by writing zero to its bit.

Register reads come back one clock after the address is presented. Register writes take effect on the clock edge where `wr_en` is high. Data lanes are aligned to each register's least significant byte: byte k of a register takes wdata byte k when `byte_en[k]` is set.

Top module: `tmr_block`

## Requirements
- R1: After a synchronous reset, every reload, counter, control and run register reads 0 and every `irq` bit is 0.
- R2: Address map (byte offsets). The run register is at 4, or at 2 when `ALT_MAP`=1. Channel n starts at 8+12n, or at 4+12n when `ALT_MAP`=1. Within a channel the reload value is at +0, the counter at +4 and the control word at +8. A read of any other offset returns 0 on `rdata` one clock later.
- R3: Bit n of the run register lets channel n count while set. While the bit is clear the counter holds its value.
- R4: Control bits 2:0 select the divisor. Codes 0, 1, 2, 3 and 4 give one decrement per 4, 16, 64, 256 and 1024 clocks. The first decrement lands on the D-th clock edge after the edge that sets the run bit.
- R5: Divisor codes 5, 6 and 7 produce no ticks, so a running counter keeps its value.
- R6: A tick that arrives with the counter at 0 loads the reload value and sets control bit 8 (the underflow flag) on the same edge.
- R7: A write with bit 8 = 0 and `byte_en[1]` set clears the flag. Writing 1 to bit 8 leaves the flag unchanged. An underflow on the same edge as a clearing write leaves the flag set.
- R8: `irq[n]` is high exactly while channel n's flag and its interrupt enable (control bit 5) are both set, and it stays high until the flag is cleared.
- R9: A counter write takes effect on the next edge whether the channel is running or stopped, and it overrides a tick on that same edge.
- R10: Writes go through byte lanes. The run register uses lane 0. The control word uses lanes 0 and 1, and its bits other than 2:0, 5 and 8 read as 0.
- R11: Clearing a channel's run bit resets its prescaler, so after a restart the full divisor period passes before the next decrement.
- R12: Channels count independently: each one decrements only by its own run bit and its own divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| byte_en | input | 4 | Byte lane enables, aligned to the register LSB |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid one clock after addr |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
Two situations are hard to reach from the ports: a clearing control write, or a counter write, landing on exactly the edge where the prescaler ticks. The bench reaches them by counting edges from the run-bit write, so that the second write meets the fourth edge of a divide-by-4 period. The prescaler reset on stop is exposed in a similar way. A channel is stopped two clocks into a period and then restarted for three clocks. A prescaler that kept its phase would decrement in that window, while a correct one would not.

// File: rtl/tmr_pkg.sv
// Shared constants, control-word type and helper functions for the timer.
// Assumes a 32-bit data path with four byte lanes.
package tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int LANES     = DATA_W / 8;
    localparam int CTRL_W    = 16;
    localparam int RUN_W     = 8;
    localparam int DIV_W     = 3;
    localparam int MAX_CODE  = 4;
    localparam int PRE_W     = 2 * MAX_CODE + 2;   // holds 1024-1
    localparam int IE_BIT    = 5;
    localparam int UF_BIT    = 8;

    typedef struct packed {
        logic             uf;
        logic             ie;
        logic [DIV_W-1:0] div;
    } ctrl_t;

    // Merge enabled byte lanes of new data into an old register value.
    function automatic logic [DATA_W-1:0] merge_lanes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [LANES-1:0]  be
    );
        logic [DATA_W-1:0] r;
        r = old_v;
        for (int k = 0; k < LANES; k++) begin
            if (be[k]) r[k*8 +: 8] = new_v[k*8 +: 8];
        end
        return r;
    endfunction

    // Place control fields at their bit positions, other bits zero.
    function automatic logic [CTRL_W-1:0] ctrl_image(input ctrl_t c);
        logic [CTRL_W-1:0] r;
        r = '0;
        r[DIV_W-1:0] = c.div;
        r[IE_BIT]    = c.ie;
        r[UF_BIT]    = c.uf;
        return r;
    endfunction
endpackage

// File: rtl/tmr_decode.sv
// Address decoder: turns a byte offset into one-hot register selects.
// Assumes offsets are compared exactly; ALT_MAP moves the whole map down.
module tmr_decode #(
    parameter int NUM_CH  = 3,
    parameter int ALT_MAP = 0,
    parameter int ADDR_W  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              run_hit,
    output logic [NUM_CH-1:0] rld_hit,
    output logic [NUM_CH-1:0] cnt_hit,
    output logic [NUM_CH-1:0] ctl_hit,
    output logic              any_hit
);
    localparam int RUN_OFS = (ALT_MAP != 0) ? 2 : 4;
    localparam int CH0_OFS = (ALT_MAP != 0) ? 4 : 8;
    localparam int STRIDE  = 12;
    localparam int RLD_REL = 0;
    localparam int CNT_REL = 4;
    localparam int CTL_REL = 8;

    // Shared run register select.
    assign run_hit = (addr == ADDR_W'(RUN_OFS));

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        localparam int BASE = CH0_OFS + n * STRIDE;
        assign rld_hit[n] = (addr == ADDR_W'(BASE + RLD_REL));
        assign cnt_hit[n] = (addr == ADDR_W'(BASE + CNT_REL));
        assign ctl_hit[n] = (addr == ADDR_W'(BASE + CTL_REL));
    end

    // Any mapped register selected.
    assign any_hit = run_hit | (|rld_hit) | (|cnt_hit) | (|ctl_hit);
endmodule

// File: rtl/tmr_prescaler.sv
// Per-channel clock divider: emits one-cycle ticks every 4^(code+1) clocks.
// Assumes codes above MAX_CODE are invalid and must stay silent; the
// divider phase returns to zero whenever run is low.
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_code,
    output logic             tick
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;
    logic             code_ok;

    // Terminal count for the selected divisor.
    always_comb begin
        code_ok = (int'(div_code) <= MAX_CODE);
        limit   = PRE_W'((32'd4 << (32'(div_code) * 2)) - 32'd1);
    end

    assign tick = run && code_ok && (pre_q >= limit);

    // Phase counter, cleared on reset, stop and terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else if (tick)      pre_q <= '0;
        else if (code_ok)   pre_q <= pre_q + 1'b1;
    end

    p_bad_code_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(div_code) > MAX_CODE) |-> !tick);
endmodule

// File: rtl/tmr_channel.sv
// One timer channel: reload, down-counter, control word and interrupt.
// Assumes write strobes are already decoded for this channel.
module tmr_channel
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  byte_en,
    input  logic              wr_rld,
    input  logic              wr_cnt,
    input  logic              wr_ctl,
    output logic [DATA_W-1:0] reload_o,
    output logic [DATA_W-1:0] count_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    ctrl_t             ctl_q;
    logic              tick;
    logic              underflow;
    logic              clear_req;

    tmr_prescaler u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .div_code (ctl_q.div),
        .tick     (tick)
    );

    assign underflow = tick && (count_q == '0);
    assign clear_req = wr_ctl && byte_en[1] && !wdata[UF_BIT];

    // Reload register, byte-lane writable.
    always_ff @(posedge clk) begin
        if (!rst_n)      reload_q <= '0;
        else if (wr_rld) reload_q <= merge_lanes(reload_q, wdata, byte_en);
    end

    // Counter: a register write wins, otherwise decrement or reload on tick.
    always_ff @(posedge clk) begin
        if (!rst_n)         count_q <= '0;
        else if (wr_cnt)    count_q <= merge_lanes(count_q, wdata, byte_en);
        else if (underflow) count_q <= reload_q;
        else if (tick)      count_q <= count_q - 1'b1;
    end

    // Divisor select and interrupt enable from lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.div <= '0;
            ctl_q.ie  <= 1'b0;
        end else if (wr_ctl && byte_en[0]) begin
            ctl_q.div <= wdata[DIV_W-1:0];
            ctl_q.ie  <= wdata[IE_BIT];
        end
    end

    // Sticky underflow flag: a new underflow beats a clearing write.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q.uf <= 1'b0;
        else if (underflow) ctl_q.uf <= 1'b1;
        else if (clear_req) ctl_q.uf <= 1'b0;
    end

    assign reload_o = reload_q;
    assign count_o  = count_q;
    assign ctrl_o   = ctrl_image(ctl_q);
    assign irq_o    = ctl_q.uf & ctl_q.ie;

    p_stopped_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_cnt) |=> (count_q == $past(count_q)));
    p_decrement_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q != '0 && !wr_cnt) |=> (count_q == $past(count_q) - 32'd1));
    p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && count_q == '0 && !wr_cnt) |=> (count_q == $past(reload_q) && ctl_q.uf));
    p_uf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.uf && !clear_req) |=> ctl_q.uf);
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cnt && byte_en == '1) |=> (count_q == $past(wdata)));
endmodule

// File: rtl/tmr_block.sv
// Timer top: shared run register, NUM_CH channels, registered read mux.
// Assumes NUM_CH is 2 or 3 and rdata is consumed one clock after addr.
module tmr_block
    import tmr_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int ALT_MAP = 0,
    parameter int ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [3:0]        byte_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic [NUM_CH-1:0] irq
);
    logic                           run_hit, any_hit;
    logic [NUM_CH-1:0]              rld_hit, cnt_hit, ctl_hit;
    logic [NUM_CH-1:0]              run_q;
    logic [NUM_CH-1:0][DATA_W-1:0]  ch_reload, ch_count;
    logic [NUM_CH-1:0][CTRL_W-1:0]  ch_ctrl;
    logic [DATA_W-1:0]              rd_next;

    tmr_decode #(.NUM_CH(NUM_CH), .ALT_MAP(ALT_MAP), .ADDR_W(ADDR_W)) u_dec (
        .addr    (addr),
        .run_hit (run_hit),
        .rld_hit (rld_hit),
        .cnt_hit (cnt_hit),
        .ctl_hit (ctl_hit),
        .any_hit (any_hit)
    );

    // Shared run bits, written through lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                           run_q <= '0;
        else if (wr_en && run_hit && byte_en[0]) run_q <= wdata[NUM_CH-1:0];
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        tmr_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run_q[n]),
            .wdata    (wdata),
            .byte_en  (byte_en),
            .wr_rld   (wr_en && rld_hit[n]),
            .wr_cnt   (wr_en && cnt_hit[n]),
            .wr_ctl   (wr_en && ctl_hit[n]),
            .reload_o (ch_reload[n]),
            .count_o  (ch_count[n]),
            .ctrl_o   (ch_ctrl[n]),
            .irq_o    (irq[n])
        );
    end

    // Select read data for the addressed register, zero if unmapped.
    always_comb begin
        rd_next = '0;
        if (run_hit) rd_next = DATA_W'(run_q);
        for (int n = 0; n < NUM_CH; n++) begin
            if (rld_hit[n]) rd_next = ch_reload[n];
            if (cnt_hit[n]) rd_next = ch_count[n];
            if (ctl_hit[n]) rd_next = DATA_W'(ch_ctrl[n]);
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= rd_next;
    end

    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> (rdata == '0));
    p_run_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && run_hit) |=> (run_q == $past(run_q)));
endmodule

// File: tb/tb_tmr_block.sv
// Scoreboard bench: read tasks queue expected values, a monitor compares.
module tb_tmr_block;
    localparam int AW = 6;
    localparam int NCH = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic            wr_en = 1'b0;
    logic [3:0]      byte_en = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    tmr_block #(.NUM_CH(NCH), .ALT_MAP(0), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .byte_en(byte_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    localparam logic [AW-1:0] A_RUN = 6'd4;
    function automatic logic [AW-1:0] a_rld(int n); return AW'(8 + 12*n); endfunction
    function automatic logic [AW-1:0] a_cnt(int n); return AW'(12 + 12*n); endfunction
    function automatic logic [AW-1:0] a_ctl(int n); return AW'(16 + 12*n); endfunction

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        addr = a; wdata = d; byte_en = be; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        addr = a; wr_en = 1'b0;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic [NCH-1:0] e, input string tag);
        @(negedge clk);
        n_chk++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq got %b expected %b", tag, irq, e);
        end
    endtask

    // Monitor: compares registered read data against the queue.
    initial forever begin
        @(posedge clk);
        #1;
        if (exp_q.size() != 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata got %h expected %h", t, rdata, e);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(A_RUN, 32'h0, "R1 run");
        rd(a_rld(0), 32'h0, "R1 reload");
        rd(a_cnt(0), 32'h0, "R1 count");
        rd(a_ctl(2), 32'h0, "R1 ctrl");
        chk_irq(3'b000, "R1 irq");

        // R2 / R10 map and byte lanes
        wr(a_rld(1), 32'hA5A5_1234, 4'hF);
        rd(a_rld(1), 32'hA5A5_1234, "R2 reload ch1");
        wr(a_rld(1), 32'h0000_FF00, 4'b0010);
        rd(a_rld(1), 32'hA5A5_FF34, "R10 lane write");
        rd(6'd0, 32'h0, "R2 unmapped 0");
        rd(6'd44, 32'h0, "R2 unmapped 44");
        wr(a_ctl(0), 32'hFFFF_FFFF, 4'b0011);
        rd(a_ctl(0), 32'h0000_0027, "R10 ctrl mask");
        wr(a_ctl(0), 32'h0, 4'b0001);
        rd(a_ctl(0), 32'h0, "R10 ctrl lane0");

        // R9 counter write while stopped; R3/R4 counting by 4
        wr(a_cnt(0), 32'd100, 4'hF);
        rd(a_cnt(0), 32'd100, "R9 stopped write");
        wr(A_RUN, 32'h1, 4'h1); idle(39); wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd90, "R4 div4 count");
        idle(10);
        rd(a_cnt(0), 32'd90, "R3 stopped hold");

        // R11 prescaler reset on stop
        wr(A_RUN, 32'h1, 4'h1); idle(5); wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd89, "R11 first run");
        wr(A_RUN, 32'h1, 4'h1); idle(2); wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd89, "R11 restart phase");

        // R4 divide by 16
        wr(a_ctl(0), 32'h1, 4'h3);
        wr(A_RUN, 32'h1, 4'h1); idle(31); wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd87, "R4 div16 count");

        // R5 invalid code
        wr(a_ctl(0), 32'h5, 4'h3);
        wr(A_RUN, 32'h1, 4'h1); idle(40); wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd87, "R5 code5 silent");

        // R6 / R8 underflow with interrupt enabled
        wr(a_ctl(0), 32'h20, 4'h3);
        wr(a_rld(0), 32'd50, 4'hF);
        wr(a_cnt(0), 32'd1, 4'hF);
        wr(A_RUN, 32'h1, 4'h1); idle(7); wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd50, "R6 reload value");
        rd(a_ctl(0), 32'h120, "R6 flag set");
        chk_irq(3'b001, "R8 irq raised");
        idle(10);
        chk_irq(3'b001, "R8 irq level held");

        // R7 write 1 keeps, write 0 clears
        wr(a_ctl(0), 32'h120, 4'h3);
        rd(a_ctl(0), 32'h120, "R7 write one keeps");
        wr(a_ctl(0), 32'h020, 4'h3);
        rd(a_ctl(0), 32'h020, "R7 write zero clears");
        chk_irq(3'b000, "R8 irq dropped");

        // R8 flag with enable off, then enable
        wr(a_ctl(0), 32'h0, 4'h3);
        wr(a_cnt(0), 32'd0, 4'hF);
        wr(A_RUN, 32'h1, 4'h1); idle(3); wr(A_RUN, 32'h0, 4'h1);
        rd(a_ctl(0), 32'h100, "R8 flag no enable");
        chk_irq(3'b000, "R8 irq masked");
        wr(a_ctl(0), 32'h120, 4'h3);
        chk_irq(3'b001, "R8 irq on enable");
        wr(a_ctl(0), 32'h020, 4'h3);

        // R7 clearing write on the underflow edge
        wr(a_cnt(0), 32'd0, 4'hF);
        wr(A_RUN, 32'h1, 4'h1); idle(3);
        wr(a_ctl(0), 32'h020, 4'h3);
        wr(A_RUN, 32'h0, 4'h1);
        rd(a_ctl(0), 32'h120, "R7 underflow beats clear");
        rd(a_cnt(0), 32'd50, "R6 reload at collision");
        wr(a_ctl(0), 32'h0, 4'h3);

        // R9 counter write on a tick edge
        wr(a_cnt(0), 32'd10, 4'hF);
        wr(A_RUN, 32'h1, 4'h1); idle(3);
        wr(a_cnt(0), 32'd500, 4'hF);
        wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(0), 32'd500, "R9 write beats tick");

        // R12 independent channels
        wr(a_cnt(1), 32'd1000, 4'hF);
        wr(a_cnt(2), 32'd1000, 4'hF);
        wr(a_ctl(2), 32'h1, 4'h3);
        wr(A_RUN, 32'h6, 4'h1);
        rd(A_RUN, 32'h6, "R3 run readback");
        idle(62);
        wr(A_RUN, 32'h0, 4'h1);
        rd(a_cnt(1), 32'd984, "R12 ch1 div4");
        rd(a_cnt(2), 32'd996, "R12 ch2 div16");
        rd(a_cnt(0), 32'd500, "R12 ch0 untouched");

        idle(4);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule